// File: doc/BRIEF.md
# DDR Serial Sample Framer

This block turns a stream of parallel converter samples into a single serial data line with two companion clocks for the receiver. One word of `WORD_BITS` bits (12 by default) goes out per sample period. Each bit occupies one half period of a forwarded data clock, so that clock runs at `WORD_BITS/2` times the sample rate, which is six times for 12 bits. A frame clock at the sample rate is high for the first half of each word and low for the second half. Its rising edge marks the first bit of a new word.

The block runs on one internal clock with `STEPS_PER_BIT` cycles per bit time, 2 by default. With that default the internal clock runs at twenty-four times the sample rate. Data and the frame clock change only at the first step of a bit. The data clock changes half a bit time later, which is a quarter of its own period. A receiver can therefore capture on both data-clock edges with the bit centred around each edge.

Samples are written into a holding register with a strobe at any time. When the last bit of a word has gone out, the next bit-time tick moves the holding register into the shift register, so words follow each other with no gap.

Timing convention: the position of a cycle is counted from the first clock edge at which `rst_i` is low. That edge produces position 0, the next edge produces position 1, and so on, modulo `WORD_BITS*STEPS_PER_BIT`. Bit `b` of a frame occupies positions `b*STEPS_PER_BIT` to `b*STEPS_PER_BIT+STEPS_PER_BIT-1`.

Top module: `ddr_sample_serializer`

## Requirements
- R1: A clock edge that samples `rst_i` high drives `data_o`, `dco_o` and `fco_o` low in the following cycle and clears the holding register to zero.
- R2: `dco_o` changes only at step `STEPS_PER_BIT/2` of a bit. It rises in the middle of the even bit positions (0, 2, ...) and falls in the middle of the odd ones, which gives `WORD_BITS/2` rising edges per frame.
- R3: `fco_o` is high during bit positions 0 to `WORD_BITS/2-1` and low during the rest. It changes only at the first step of a bit.
- R4: Bit position `b` of a frame carries bit `WORD_BITS-1-b` of that frame's word, so the most significant bit is sent first. `data_o` changes only at the first step of a bit.
- R5: The first cycle after reset is released shows bit position 0: `fco_o` is high and `data_o` is the MSB of the cleared holding register (0).
- R6: A frame's word is the holding-register content before the edge that produces position 0. A strobe sampled at that same edge lands in the holding register and is sent in the following frame.
- R7: The holding register takes `sample_i` only at edges where `sample_we_i` is high. With several strobes before one load, the last one is sent. A change of `sample_i` without a strobe leaves the serial output unchanged.
- R8: Frames follow back to back: consecutive rising edges of `fco_o` are exactly `WORD_BITS*STEPS_PER_BIT` cycles apart.
- R9: A reset asserted in the middle of a frame abandons that word. After release the output restarts at bit position 0 with a zero word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal clock, `STEPS_PER_BIT` cycles per bit time |
| rst_i | input | 1 | Synchronous active-high reset |
| sample_i | input | WORD_BITS | Parallel sample to be sent |
| sample_we_i | input | 1 | Writes `sample_i` into the holding register |
| data_o | output | 1 | Serial data, MSB first, one bit per data-clock half period |
| dco_o | output | 1 | Forwarded data clock, edges centred in each bit |
| fco_o | output | 1 | Frame clock, high for the first half of each word |

## Verification
The bench sends fixed words that separate likely faults:
- all zeros and all ones show a stuck line;
- the two alternating patterns show a bit slipped by one position;
- a lone MSB and a lone LSB show a reversed bit order.

Writes placed in the last two cycles of a frame separate a load taken before the strobe from one taken after it. Several strobes in one frame, followed by an unstrobed bus change, show which value the holding register keeps. Random words written at random positions are compared cycle by cycle against a position-based model of data, frame clock and data clock. Reset is applied both at start-up and in the middle of a frame.

// File: rtl/ddr_ser_pkg.sv
package ddr_ser_pkg;

  localparam int DEF_WORD_BITS = 12;
  localparam int DEF_STEPS     = 2;

  // counter width for a modulus n, never narrower than one bit
  function automatic int width_of(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/ddr_ser_timing.sv
module ddr_ser_timing
  import ddr_ser_pkg::*;
#(
  parameter int WORD_BITS     = DEF_WORD_BITS,
  parameter int STEPS_PER_BIT = DEF_STEPS,
  parameter int SUB_W         = width_of(STEPS_PER_BIT),
  parameter int BIT_W         = width_of(WORD_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  output logic [SUB_W-1:0] sub_q,
  output logic [BIT_W-1:0] bit_q,
  output logic             bit_tick,
  output logic             word_start
);

  localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(STEPS_PER_BIT - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_BITS - 1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sub_q <= '0;
      bit_q <= '0;
    end else if (sub_q == LAST_SUB) begin
      sub_q <= '0;
      bit_q <= (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
    end else begin
      sub_q <= sub_q + 1'b1;
    end
  end

  assign bit_tick   = (sub_q == '0);
  assign word_start = bit_tick && (bit_q == '0);

endmodule

// File: rtl/ddr_ser_hold.sv
module ddr_ser_hold
  import ddr_ser_pkg::*;
#(
  parameter int WORD_BITS = DEF_WORD_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 we_i,
  input  logic [WORD_BITS-1:0] din_i,
  output logic [WORD_BITS-1:0] hold_q
);

  always_ff @(posedge clk_i) begin
    if (rst_i)     hold_q <= '0;
    else if (we_i) hold_q <= din_i;
  end

endmodule

// File: rtl/ddr_ser_shift.sv
module ddr_ser_shift
  import ddr_ser_pkg::*;
#(
  parameter int WORD_BITS = DEF_WORD_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 load_i,
  input  logic                 shift_i,
  input  logic [WORD_BITS-1:0] word_i,
  output logic                 data_q
);

  logic [WORD_BITS-1:0] sh_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sh_q   <= '0;
      data_q <= 1'b0;
    end else if (load_i) begin
      data_q <= word_i[WORD_BITS-1];
      sh_q   <= {word_i[WORD_BITS-2:0], 1'b0};
    end else if (shift_i) begin
      data_q <= sh_q[WORD_BITS-1];
      sh_q   <= {sh_q[WORD_BITS-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/ddr_ser_clkgen.sv
module ddr_ser_clkgen
  import ddr_ser_pkg::*;
#(
  parameter int WORD_BITS     = DEF_WORD_BITS,
  parameter int STEPS_PER_BIT = DEF_STEPS,
  parameter int SUB_W         = width_of(STEPS_PER_BIT),
  parameter int BIT_W         = width_of(WORD_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic [BIT_W-1:0] bit_i,
  output logic             dco_q,
  output logic             fco_q
);

  localparam logic [SUB_W-1:0] HALF_SUB  = SUB_W'(STEPS_PER_BIT / 2);
  localparam logic [BIT_W-1:0] HALF_WORD = BIT_W'(WORD_BITS / 2);

  // both clocks decoded from the position, so they cannot drift apart
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dco_q <= 1'b0;
      fco_q <= 1'b0;
    end else begin
      dco_q <= bit_i[0] ^ (sub_i >= HALF_SUB);
      fco_q <= (bit_i < HALF_WORD);
    end
  end

endmodule

// File: rtl/ddr_sample_serializer.sv
module ddr_sample_serializer
  import ddr_ser_pkg::*;
#(
  parameter int WORD_BITS     = DEF_WORD_BITS,
  parameter int STEPS_PER_BIT = DEF_STEPS
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [WORD_BITS-1:0] sample_i,
  input  logic                 sample_we_i,
  output logic                 data_o,
  output logic                 dco_o,
  output logic                 fco_o
);

  localparam int SUB_W = width_of(STEPS_PER_BIT);
  localparam int BIT_W = width_of(WORD_BITS);

  logic [SUB_W-1:0]     sub_cnt;
  logic [BIT_W-1:0]     bit_cnt;
  logic                 bit_tick;
  logic                 word_start;
  logic [WORD_BITS-1:0] hold_q;

  ddr_ser_timing #(
    .WORD_BITS(WORD_BITS), .STEPS_PER_BIT(STEPS_PER_BIT),
    .SUB_W(SUB_W), .BIT_W(BIT_W)
  ) timing_i (
    .clk_i(clk_i), .rst_i(rst_i),
    .sub_q(sub_cnt), .bit_q(bit_cnt),
    .bit_tick(bit_tick), .word_start(word_start)
  );

  ddr_ser_hold #(.WORD_BITS(WORD_BITS)) hold_i (
    .clk_i(clk_i), .rst_i(rst_i),
    .we_i(sample_we_i), .din_i(sample_i), .hold_q(hold_q)
  );

  ddr_ser_shift #(.WORD_BITS(WORD_BITS)) shift_i (
    .clk_i(clk_i), .rst_i(rst_i),
    .load_i(word_start), .shift_i(bit_tick && !word_start),
    .word_i(hold_q), .data_q(data_o)
  );

  ddr_ser_clkgen #(
    .WORD_BITS(WORD_BITS), .STEPS_PER_BIT(STEPS_PER_BIT),
    .SUB_W(SUB_W), .BIT_W(BIT_W)
  ) clkgen_i (
    .clk_i(clk_i), .rst_i(rst_i),
    .sub_i(sub_cnt), .bit_i(bit_cnt),
    .dco_q(dco_o), .fco_q(fco_o)
  );

endmodule

// File: rtl/ddr_sample_serializer_chk.sv
module ddr_sample_serializer_chk #(
  parameter int WORD_BITS     = 12,
  parameter int STEPS_PER_BIT = 2,
  parameter int SUB_W         = 1
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             data_o,
  input logic             dco_o,
  input logic             fco_o,
  input logic [SUB_W-1:0] sub_q
);

  localparam int FRAME = WORD_BITS * STEPS_PER_BIT;
  localparam int FR_W  = $clog2(FRAME) + 1;
  // step counter value one edge after the output changed
  localparam logic [SUB_W-1:0] AFTER_START = SUB_W'(1 % STEPS_PER_BIT);
  localparam logic [SUB_W-1:0] AFTER_MID   = SUB_W'((STEPS_PER_BIT / 2 + 1) % STEPS_PER_BIT);

  logic [FR_W-1:0] gap_cnt;
  logic            fco_prev;
  logic            seen_rise;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gap_cnt   <= '0;
      fco_prev  <= 1'b0;
      seen_rise <= 1'b0;
    end else begin
      fco_prev <= fco_o;
      if (fco_o && !fco_prev) begin
        gap_cnt   <= '0;
        seen_rise <= 1'b1;
      end else begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (!data_o && !dco_o && !fco_o));

  assert_dco_midbit_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$stable(dco_o)) |-> (sub_q == AFTER_MID));

  assert_fco_on_bit_edge_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$stable(fco_o)) |-> (sub_q == AFTER_START));

  assert_data_on_bit_edge_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$stable(data_o)) |-> (sub_q == AFTER_START));

  assert_frame_period_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (fco_o && !fco_prev && seen_rise) |-> (gap_cnt == FR_W'(FRAME - 1)));

endmodule

bind ddr_sample_serializer ddr_sample_serializer_chk #(
  .WORD_BITS(WORD_BITS), .STEPS_PER_BIT(STEPS_PER_BIT), .SUB_W(SUB_W)
) chk_i (
  .clk_i(clk_i), .rst_i(rst_i),
  .data_o(data_o), .dco_o(dco_o), .fco_o(fco_o),
  .sub_q(sub_cnt)
);

// File: tb/ddr_sample_serializer_tb_top.sv
module ddr_sample_serializer_tb_top;

  localparam int W     = 12;
  localparam int S     = 2;
  localparam int FRAME = W * S;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] sample = '0;
  logic         we = 1'b0;
  logic         data, dco, fco;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ddr_sample_serializer #(.WORD_BITS(W), .STEPS_PER_BIT(S)) dut_i (
    .clk_i(clk), .rst_i(rst), .sample_i(sample), .sample_we_i(we),
    .data_o(data), .dco_o(dco), .fco_o(fco)
  );

  function automatic bit exp_dco(input int b, input int s);
    return ((b % 2) == 1) ^ (s >= S / 2);
  endfunction

  function automatic bit exp_fco(input int b);
    return b < W / 2;
  endfunction

  function automatic bit exp_bit(input logic [W-1:0] w, input int b);
    return w[W-1-b];
  endfunction

  // position-based reference model
  int           m_pos = 0;
  int           shown = -1;
  logic [W-1:0] m_hold = '0;
  logic [W-1:0] m_word = '0;
  logic         e_data = 1'b0, e_dco = 1'b0, e_fco = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; shown = -1; m_hold = '0;
      e_data = 1'b0; e_dco = 1'b0; e_fco = 1'b0;
    end else begin
      if (m_pos == 0) m_word = m_hold;
      e_data = exp_bit(m_word, m_pos / S);
      e_fco  = exp_fco(m_pos / S);
      e_dco  = exp_dco(m_pos / S, m_pos % S);
      shown  = m_pos;
      m_pos  = (m_pos + 1) % FRAME;
      if (we) m_hold = sample;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(data === e_data, "R4/R6/R7 serial bit", data, e_data);
      chk(fco === e_fco, "R3 frame clock", fco, e_fco);
      chk(dco === e_dco, "R2 data clock", dco, e_dco);
    end
  end

  task automatic wait_pos(input int p);
    do @(negedge clk); while (shown != p);
  endtask

  task automatic put(input logic [W-1:0] v);
    sample = v;
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic grab(output logic [W-1:0] w);
    if (shown != 0) wait_pos(0);
    for (int b = 0; b < W; b++) begin
      if (b > 0) wait_pos(b * S);
      w[W-1-b] = data;
    end
  endtask

  task automatic check_word(input logic [W-1:0] exp, input string tag);
    logic [W-1:0] got;
    grab(got);
    chk(got === exp, tag, got, exp);
  endtask

  initial begin
    logic [W-1:0] pats [6];
    int           cyc, rises;
    logic         pf, pd, rose;
    int unsigned  v, p;
    void'($urandom(32'h1bad5eed));
    pats = '{12'h000, 12'hFFF, 12'hAAA, 12'h555, 12'h800, 12'h001};

    repeat (3) @(posedge clk);
    cmp_en = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk({data, dco, fco} === 3'b000, "R1 outputs low in reset", {data, dco, fco}, 0);
    end
    rst = 1'b0;
    @(negedge clk);
    chk(fco === 1'b1, "R5 first cycle is bit 0", fco, 1);
    chk(data === 1'b0, "R5 first bit from cleared hold", data, 0);
    check_word('0, "R1 holding register cleared");

    foreach (pats[i]) begin
      wait_pos(5);
      put(pats[i]);
      check_word(pats[i], "R4 MSB-first pattern");
    end

    // R6: load edge versus strobe timing
    wait_pos(5);
    put(12'h3C5);
    wait_pos(FRAME - 1);
    put(12'hA5C);
    check_word(12'h3C5, "R6 load takes prior content");
    check_word(12'hA5C, "R6 strobe on load edge deferred");
    wait_pos(FRAME - 2);
    put(12'h6E1);
    check_word(12'h6E1, "R6 strobe one cycle before load");

    // R7: last strobe wins, unstrobed bus changes ignored
    wait_pos(2);
    put(12'h123);
    put(12'hD4B);
    sample = 12'hF0F;
    wait_pos(9);
    sample = 12'h0F0;
    check_word(12'hD4B, "R7 last write wins, unstrobed ignored");
    check_word(12'hD4B, "R7 word repeats without strobe");

    // R8 / R2: frame spacing and data-clock edges per frame
    pf = fco;
    do begin @(negedge clk); rose = fco && !pf; pf = fco; end while (!rose);
    repeat (3) begin
      cyc = 0; rises = 0; pd = dco; pf = fco;
      do begin
        @(negedge clk);
        cyc++;
        if (dco && !pd) rises++;
        pd = dco;
        rose = fco && !pf;
        pf = fco;
      end while (!rose && cyc < 4 * FRAME);
      chk(cyc == FRAME, "R8 cycles between frame starts", cyc, FRAME);
      chk(rises == W / 2, "R2 data clock rises per frame", rises, W / 2);
    end

    // R9: reset in the middle of a frame
    wait_pos(5);
    put(12'hFFF);
    wait_pos(9);
    rst = 1'b1;
    @(negedge clk);
    chk({data, dco, fco} === 3'b000, "R9 outputs low on mid-frame reset", {data, dco, fco}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(fco === 1'b1, "R9 restart at bit 0", fco, 1);
    chk(data === 1'b0, "R9 abandoned word not resumed", data, 0);
    check_word('0, "R9 zero word after reset");
    wait_pos(5);
    put(12'h9A3);
    check_word(12'h9A3, "R9 normal framing resumes");

    // random words at random write positions
    repeat (40) begin
      v = $urandom;
      p = $urandom_range(0, FRAME - 3);
      wait_pos(int'(p));
      if ($urandom_range(0, 3) != 0) put(v[W-1:0]);
      wait_pos(FRAME - 2);
    end

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule